// File: doc/BRIEF.md
# Multiplexed Delta-Sigma ADC Controller

This block lets a single one-bit delta-sigma modulator measure several analog inputs in turn, for example the rectified mains, the boost switch drain, the current shunt and the storage bus. It drives the select code of the analog multiplexer in front of the modulator. For each selected input it waits a settling time and then integrates a fixed window of modulator bits through a second-order integrate-and-dump decimator. It scales the sum to a 12-bit raw value and publishes a corrected result for that channel together with a one-cycle valid strobe.

Calibration runs without stopping the measurements. After every round of channel conversions, the block converts a zero reference and then a full-scale reference. From these two conversions it updates an offset and a Q1.11 gain factor, and all later channel results use them. A driver-switching blank input marks cycles in which the power stage is switching. Any settling or sampling window that contains a blank cycle is thrown away, and the same input is settled and converted again from the start.

Top module: `adc_seq_top`

## Requirements
- R1: After reset `muxSel` steps through 0 to NUM_CH-1 (the measured channels), then NUM_CH (zero reference), then NUM_CH+1 (full-scale reference), and then returns to 0, advancing exactly once per completed slot.
- R2: Without blanking, each slot takes SETTLE settle cycles, then DECIM sampling cycles, then one finish cycle, so that `muxSel` advances SETTLE+DECIM+1 clock edges after the previous advance. After the full-scale slot, a further 23 cycles (RES_W+GAIN_FRAC) of gain computation are added before the settle of slot 0 begins, while `muxSel` already reads 0.
- R3: The raw value of a slot is S = sum over the DECIM sampled bits b_j (j = 0 oldest) of b_j*(DECIM-j). This sum is shifted right by clog2(S_max+1)-12 where that is positive, or left by the negative of it otherwise, where S_max = DECIM*(DECIM+1)/2.
- R4: A channel result is min(4095, (max(raw-offset, 0) * gain) >> 11). Before the first calibration, offset is 0 and gain is 2048 (1.0).
- R5: The raw value of the zero-reference slot becomes the offset for every channel result completed after it.
- R6: After the full-scale slot, the gain becomes min(4095, floor(4095*2048/span)), where span = max(raw_full - offset, 0). A span of 0 gives a gain of 4095.
- R7: A `blank` high at a clock edge during settling or sampling restarts the same slot. `muxSel` holds its value and advances SETTLE+DECIM+1 edges after that blank edge, and the result uses only bits sampled after the restart.
- R8: A `blank` high during the finish cycle or the gain computation has no effect on slot timing.
- R9: `resultValid` bit k pulses for one cycle when slot k finishes, in the cycle in which `muxSel` advances and `results[k*12 +: 12]` takes its new value. Calibration slots pulse no valid bit, and a result changes only together with its strobe.
- R10: While reset is low, `muxSel`, `results` and `resultValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modBit | input | 1 | One-bit modulator output |
| blank | input | 1 | High while the power drivers are switching |
| muxSel | output | clog2(NUM_CH+2) | Analog multiplexer select: channels, then zero ref, then full-scale ref |
| results | output | NUM_CH*12 | Corrected 12-bit result per channel, channel k at bits k*12 upward |
| resultValid | output | NUM_CH | One-cycle strobe per channel when its result updates |

## Verification
The bench builds the block with NUM_CH=4, DECIM=90 and SETTLE=4. With DECIM=90 the weighted sum reaches exactly 4095 at full scale, so raw values need no shift, and the gain reaches useful values below its 2.0 ceiling. The short slots allow six full rounds in a few thousand cycles. Across these rounds the channel densities are swept, the extreme all-zero and all-one inputs are covered, and one round has a full-scale reference that falls below the zero reference, which forces the gain to saturate. Blank pulses are placed in settling, in sampling and in the gain computation, so that the restart timing and the ignored cases are all checked against edge counts computed in the bench.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {PH_SETTLE, PH_SAMPLE, PH_FINISH, PH_DIVIDE} seqPhase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clr;      // clear decimator integrators
    logic smp;      // integrate the current modulator bit
    logic fin;      // slot finished, capture result of the current slot
    logic divStep;  // one restoring-division step for the gain
    logic divLast;  // final division step, load gain
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DECIM     = 1000,
  parameter int SETTLE    = 16,
  parameter int DIV_STEPS = 23
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          blank,
  output seqStrobe_t                    stb,
  output logic [$clog2(NUM_CH+2)-1:0]   slot
);
  localparam int SELW = $clog2(NUM_CH + 2);
  localparam int M1   = (DECIM > SETTLE) ? DECIM : SETTLE;
  localparam int M2   = (M1 > DIV_STEPS) ? M1 : DIV_STEPS;
  localparam int CW   = $clog2(M2 + 1);
  localparam logic [SELW-1:0] LAST = SELW'(NUM_CH + 1);

  seqPhase_t phase;
  logic [CW-1:0] cnt;

  always_comb begin
    stb.clr     = (phase == PH_SETTLE);
    stb.smp     = (phase == PH_SAMPLE) && !blank;
    stb.fin     = (phase == PH_FINISH);
    stb.divStep = (phase == PH_DIVIDE);
    stb.divLast = (phase == PH_DIVIDE) && (cnt == CW'(DIV_STEPS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_SETTLE;
      cnt   <= '0;
      slot  <= '0;
    end else begin
      unique case (phase)
        PH_SETTLE: begin
          if (blank) cnt <= '0;
          else if (cnt == CW'(SETTLE - 1)) begin
            phase <= PH_SAMPLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_SAMPLE: begin
          if (blank) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
          end else if (cnt == CW'(DECIM - 1)) begin
            phase <= PH_FINISH;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_FINISH: begin
          cnt <= '0;
          if (slot == LAST) begin
            slot  <= '0;
            phase <= PH_DIVIDE;
          end else begin
            slot  <= slot + 1'b1;
            phase <= PH_SETTLE;
          end
        end
        PH_DIVIDE: begin
          if (cnt == CW'(DIV_STEPS - 1)) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_SETTLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DECIM     = 1000,
  parameter int RES_W     = 12,
  parameter int GAIN_FRAC = 11
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modBit,
  input  seqStrobe_t                    stb,
  input  logic [$clog2(NUM_CH+2)-1:0]   slot,
  output logic [NUM_CH*RES_W-1:0]       results,
  output logic [NUM_CH-1:0]             resultValid
);
  localparam int SELW = $clog2(NUM_CH + 2);
  localparam int FULL = DECIM * (DECIM + 1) / 2;
  localparam int SUMW = $clog2(FULL + 1);
  localparam int S1W  = $clog2(DECIM + 1);
  localparam int DVW  = RES_W + GAIN_FRAC;
  localparam int PW   = 2 * RES_W;
  localparam logic [RES_W-1:0] MAXV   = {RES_W{1'b1}};
  localparam logic [DVW-1:0]   DVD    = DVW'(MAXV) << GAIN_FRAC;
  localparam logic [SELW-1:0]  ZSLOT  = SELW'(NUM_CH);
  localparam logic [SELW-1:0]  FSLOT  = SELW'(NUM_CH + 1);

  // second-order integrate-and-dump decimator
  logic [S1W-1:0]  s1, s1Next;
  logic [SUMW-1:0] s2;
  logic [RES_W-1:0] raw;

  assign s1Next = s1 + S1W'(modBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1 <= '0;
      s2 <= '0;
    end else if (stb.clr) begin
      s1 <= '0;
      s2 <= '0;
    end else if (stb.smp) begin
      s1 <= s1Next;
      s2 <= s2 + SUMW'(s1Next);
    end
  end

  generate
    if (SUMW > RES_W) begin : g_shr
      assign raw = RES_W'(s2 >> (SUMW - RES_W));
    end else begin : g_shl
      assign raw = RES_W'(s2) << (RES_W - SUMW);
    end
  endgenerate

  // correction and gain division
  logic [RES_W-1:0] offset, gain, divisor, diff, span, corr;
  logic [PW-1:0]    prod, scaled;
  logic [RES_W:0]   rem, remShift;
  logic [DVW-1:0]   dvd, quot, quotNext;
  logic             remFits;

  always_comb begin
    diff     = (raw > offset) ? raw - offset : '0;
    prod     = PW'(diff) * PW'(gain);
    scaled   = prod >> GAIN_FRAC;
    corr     = (scaled > PW'(MAXV)) ? MAXV : scaled[RES_W-1:0];
    span     = (raw > offset) ? raw - offset : '0;
    remShift = {rem[RES_W-1:0], dvd[DVW-1]};
    remFits  = remShift >= {1'b0, divisor};
    quotNext = {quot[DVW-2:0], remFits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset  <= '0;
      gain    <= RES_W'(1) << GAIN_FRAC;
      divisor <= '0;
      rem     <= '0;
      dvd     <= '0;
      quot    <= '0;
    end else begin
      if (stb.fin && slot == ZSLOT) offset <= raw;
      if (stb.fin && slot == FSLOT) begin
        divisor <= span;
        dvd     <= DVD;
        rem     <= '0;
        quot    <= '0;
      end
      if (stb.divStep) begin
        dvd  <= dvd << 1;
        rem  <= remFits ? remShift - {1'b0, divisor} : remShift;
        quot <= quotNext;
      end
      if (stb.divLast)
        gain <= (quotNext > DVW'(MAXV)) ? MAXV : quotNext[RES_W-1:0];
    end
  end

  // per-channel result registers and strobes
  logic [RES_W-1:0] resReg [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= '0;
      for (int k = 0; k < NUM_CH; k++) resReg[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_CH; k++) begin
        resultValid[k] <= stb.fin && (slot == SELW'(k));
        if (stb.fin && slot == SELW'(k)) resReg[k] <= corr;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
      assign results[g*RES_W +: RES_W] = resReg[g];
    end
  endgenerate
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DECIM     = 1000,
  parameter int SETTLE    = 16,
  parameter int RES_W     = 12,
  parameter int GAIN_FRAC = 11
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modBit,
  input  logic                          blank,
  output logic [$clog2(NUM_CH+2)-1:0]   muxSel,
  output logic [NUM_CH*RES_W-1:0]       results,
  output logic [NUM_CH-1:0]             resultValid
);
  localparam int DIV_STEPS = RES_W + GAIN_FRAC;

  seqStrobe_t seqStb;

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .DECIM(DECIM), .SETTLE(SETTLE), .DIV_STEPS(DIV_STEPS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .blank(blank), .stb(seqStb), .slot(muxSel)
  );

  adc_seq_dpath #(
    .NUM_CH(NUM_CH), .DECIM(DECIM), .RES_W(RES_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .modBit(modBit), .stb(seqStb), .slot(muxSel),
    .results(results), .resultValid(resultValid)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 12
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          blank,
  input logic                          finStb,
  input logic [$clog2(NUM_CH+2)-1:0]   muxSel,
  input logic [NUM_CH*RES_W-1:0]       results,
  input logic [NUM_CH-1:0]             resultValid
);
  localparam int SELW = $clog2(NUM_CH + 2);
  localparam logic [SELW-1:0] LAST = SELW'(NUM_CH + 1);

  a_r1_sel_range: assert property (@(posedge clk) disable iff (!rstN)
    muxSel <= LAST);

  a_r1_sel_order: assert property (@(posedge clk) disable iff (!rstN)
    (muxSel != $past(muxSel)) |->
      (muxSel == (($past(muxSel) == LAST) ? '0 : $past(muxSel) + 1'b1)));

  a_r9_valid_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resultValid));

  a_r9_valid_on_advance: assert property (@(posedge clk) disable iff (!rstN)
    (|resultValid) |-> (muxSel != $past(muxSel)));

  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(|resultValid) |-> $stable(results));

  a_r7_blank_no_finish: assert property (@(posedge clk) disable iff (!rstN)
    blank |=> !finStb);
endmodule

bind adc_seq_top adc_seq_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .blank(blank), .finStb(seqStb.fin),
  .muxSel(muxSel), .results(results), .resultValid(resultValid)
);

// File: tb/adc_seq_top_test.sv
module adc_seq_top_test;
  localparam int NUM_CH = 4;
  localparam int DECIM  = 90;
  localparam int SETTLE = 4;
  localparam int DIVS   = 23;
  localparam int PERIOD = SETTLE + DECIM + 1;
  localparam int SELW   = $clog2(NUM_CH + 2);

  logic clk = 1'b0;
  logic rstN, modBit, blank;
  logic [SELW-1:0] muxSel;
  logic [NUM_CH*12-1:0] results;
  logic [NUM_CH-1:0] resultValid;

  adc_seq_top #(.NUM_CH(NUM_CH), .DECIM(DECIM), .SETTLE(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .modBit(modBit), .blank(blank),
    .muxSel(muxSel), .results(results), .resultValid(resultValid)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int edgeCnt = 0;
  bit bitLog [0:255];

  always @(posedge clk) begin
    edgeCnt = edgeCnt + 1;
    bitLog[edgeCnt & 255] = modBit;
  end

  int lvl [0:5];
  int acc [0:5];
  int off = 0, gn = 2048, rounds = 0;
  int prevSel = 0, sinceSel = 0, prevE = 0, blankEdge = 0;
  bit firstSlot = 1, prevFull = 0, blankRestart = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setLevels(input int r);
    for (int k = 0; k < NUM_CH; k++) lvl[k] = (r * 53 + k * 71 + 9) % 257;
    if (r == 0) begin
      lvl[0] = 0; lvl[1] = 256; lvl[2] = 128; lvl[3] = 1;
    end
    lvl[4] = 16;
    lvl[5] = (r == 3) ? 0 : 240;
  endtask

  task automatic finishSlot(input int sel, input int e);
    int raw, nxt, expE, diff, corr, span;
    raw = 0;
    for (int j = 0; j < DECIM; j++)
      raw += (bitLog[(e - DECIM + j) & 255] ? 1 : 0) * (DECIM - j);
    // R1: ordered slot sequence
    nxt = (sel == NUM_CH + 1) ? 0 : sel + 1;
    check(int'(muxSel) == nxt, "R1 select order", int'(muxSel), nxt);
    // R2 / R7 / R8: slot timing
    if (!firstSlot) begin
      if (blankRestart) begin
        expE = blankEdge + PERIOD;
        check(e == expE, "R7 restart timing", e, expE);
      end else begin
        expE = prevE + (prevFull ? DIVS : 0) + PERIOD;
        check(e == expE, (prevFull ? "R2 R8 slot timing after gain" : "R2 slot timing"), e, expE);
      end
    end
    if (sel < NUM_CH) begin
      diff = (raw > off) ? raw - off : 0;
      corr = (diff * gn) >>> 11;
      if (corr > 4095) corr = 4095;
      check(resultValid == NUM_CH'(1 << sel), "R9 valid strobe", int'(resultValid), 1 << sel);
      check(int'(results[sel*12 +: 12]) == corr,
            (rounds == 0) ? "R3 R4 raw result" : "R4 R5 R6 corrected result",
            int'(results[sel*12 +: 12]), corr);
    end else begin
      check(resultValid == '0, "R9 no strobe on calibration", int'(resultValid), 0);
      if (sel == NUM_CH) off = raw;
      else begin
        span = (raw > off) ? raw - off : 0;
        gn = (span == 0) ? 4095 : (4095 * 2048) / span;
        if (gn > 4095) gn = 4095;
        rounds++;
        setLevels(rounds);
      end
    end
    prevE = e;
    prevFull = (sel == NUM_CH + 1);
    blankRestart = 0;
    firstSlot = 0;
  endtask

  initial begin
    bit done;
    rstN = 1'b0; modBit = 1'b0; blank = 1'b0;
    for (int k = 0; k < 6; k++) acc[k] = 0;
    setLevels(0);
    repeat (3) @(negedge clk);
    // R10: reset state
    check(muxSel == '0, "R10 reset select", int'(muxSel), 0);
    check(resultValid == '0, "R10 reset valid", int'(resultValid), 0);
    check(results == '0, "R10 reset results", int'(results[11:0]), 0);
    rstN = 1'b1;
    done = 0;
    for (int cyc = 0; cyc < 20000 && !done; cyc++) begin
      @(negedge clk);
      if (int'(muxSel) != prevSel) begin
        finishSlot(prevSel, edgeCnt);
        prevSel = int'(muxSel);
        sinceSel = 0;
      end else sinceSel++;
      if (rounds >= 6) done = 1;
      blank = 1'b0;
      if (rounds == 1 && prevSel == 2 && sinceSel == 30) begin
        blank = 1'b1; blankRestart = 1; blankEdge = edgeCnt + 1;   // R7 during sampling
      end
      if (rounds == 2 && prevSel == 1 && sinceSel == 2) begin
        blank = 1'b1; blankRestart = 1; blankEdge = edgeCnt + 1;   // R7 during settling
      end
      if (rounds == 2 && prevSel == 0 && sinceSel == 5) blank = 1'b1;  // R8 during gain divide
      acc[prevSel] += lvl[prevSel];
      if (acc[prevSel] >= 256) begin
        modBit = 1'b1;
        acc[prevSel] -= 256;
      end else modBit = 1'b0;
    end
    if (!done) check(1'b0, "watchdog", rounds, 6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule